// File: doc/BRIEF.md
# Scaled-Index Address Unit

This combinational unit sits in the execute stage of a 64-bit integer core and forms scaled-index addresses and related sums. For the three shift-add operations it multiplies the first source operand by 2, 4 or 8 and adds the second source operand. It also accepts word forms that treat the first operand as a 32-bit unsigned index. A plain unsigned-word add and an unsigned-word left shift by an immediate are handled as well. The instruction word and both register operands come in, and the 64-bit result and a flag that marks a recognised encoding go out in the same cycle.

Decoding, the conditioning of the first operand, the shift and the add are split into separate modules. The parameters set the datapath width, the width of the unsigned index and the split point of the adder. A parameter also selects between a single-carry adder and a carry-select adder. Elaboration-time checks reject parameter sets that the encoding cannot support.

Top module: `scaled_index_agu`

## Requirements
- R1: With opcode bits [6:0] = 0110011, funct7 bits [31:25] = 0010000 and funct3 bits [14:12] of 010, 100 or 110, the result is (rs1 << n) + rs2 with n = 1, 2 or 3 respectively, and valid is 1.
- R2: Every result is a full 64-bit value taken modulo 2^64. Carries and shifted-out bits above bit 63 are dropped, and there is no sign extension from bit 31.
- R3: With opcode 0111011 and the same funct7 and funct3 values as R1, bits 63:32 of rs1 are cleared before the shift, so the result is ({32'b0, rs1[31:0]} << n) + rs2, and valid is 1.
- R4: With opcode 0111011, funct7 0000100 and funct3 000, the result is {32'b0, rs1[31:0]} + rs2, and valid is 1.
- R5: With opcode 0011011, bits [31:26] = 000010 and funct3 001, the result is {32'b0, rs1[31:0]} shifted left by the 6-bit amount in bits [25:20], and valid is 1.
- R6: For the R5 operation, bits shifted past bit 63 are discarded, and rs2 has no effect on the result.
- R7: The destination and source register index fields (bits [11:7] and [19:15], and bits [24:20] of the register forms) do not change the result.
- R8: Any other encoding gives valid = 0 and result = 0. This includes funct3 000 or an odd funct3 with the shift-add funct7, a different funct7, a different opcode, and the R5 encoding with bit 26 set.
- R9: The outputs follow the inputs combinationally, with no clock and no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode |
| rs1_i | input | 64 | First source operand (the index) |
| rs2_i | input | 64 | Second source operand (the base) |
| result_o | output | 64 | Computed sum or shifted value, zero when not valid |
| valid_o | output | 1 | High when the encoding is one of the supported operations |

## Verification
The embedded checks hold on every evaluation. They confirm that a full-width shift-add gives back the shifted operand once the base is subtracted, that the word forms never produce bits above the index width plus the shift, and that the unsigned-word add gives back the low word. They also confirm that the shifter leaves zeros below the shift amount, that the adder inverts through subtraction, and that a rejected encoding gives a zero result. Only the directed scenarios can show the exact decode boundaries. These include which funct3, funct7 and opcode values are accepted and that bit 26 rejects the immediate shift. The scenarios also cover discarding at bit 63, wrap-around of the carry, and the fact that register index fields and the unused base operand leave the result untouched.

// File: rtl/agu_pkg.sv
package agu_pkg;
   localparam logic [6:0] MAJ_REG     = 7'b0110011;
   localparam logic [6:0] MAJ_REG_W   = 7'b0111011;
   localparam logic [6:0] MAJ_IMM_W   = 7'b0011011;
   localparam logic [6:0] F7_SCALE    = 7'b0010000;
   localparam logic [6:0] F7_WADD     = 7'b0000100;
   localparam logic [5:0] TOP6_WSHIFT = 6'b000010;
   localparam logic [2:0] F3_WADD     = 3'b000;
   localparam logic [2:0] F3_WSHIFT   = 3'b001;

   typedef enum logic [1:0] {
      K_NONE   = 2'd0,
      K_SCALE  = 2'd1,
      K_WADD   = 2'd2,
      K_WSHIFT = 2'd3
   } agu_kind_e;
endpackage

// File: rtl/agu_decode.sv
module agu_decode
   import agu_pkg::*;
#(
   parameter int XLEN = 64,
   localparam int SHW = $clog2(XLEN)
) (
   input  logic [31:0]    instr,
   output agu_kind_e      kind,
   output logic           zext,
   output logic           use_base,
   output logic [SHW-1:0] amount
);
   logic [6:0] major;
   logic [2:0] f3;
   logic [6:0] f7;
   logic       scale_ok;

   assign major = instr[6:0];
   assign f3    = instr[14:12];
   assign f7    = instr[31:25];
   // even funct3 other than 000 selects a scale of 1..3
   assign scale_ok = (f7 == F7_SCALE) && !f3[0] && (f3[2:1] != 2'b00);

   always_comb begin
      kind     = K_NONE;
      zext     = 1'b0;
      use_base = 1'b0;
      amount   = '0;
      case (major)
         MAJ_REG: begin
            if (scale_ok) begin
               kind     = K_SCALE;
               use_base = 1'b1;
               amount   = SHW'(f3[2:1]);
            end
         end
         MAJ_REG_W: begin
            if (scale_ok) begin
               kind     = K_SCALE;
               zext     = 1'b1;
               use_base = 1'b1;
               amount   = SHW'(f3[2:1]);
            end else if (f7 == F7_WADD && f3 == F3_WADD) begin
               kind     = K_WADD;
               zext     = 1'b1;
               use_base = 1'b1;
            end
         end
         MAJ_IMM_W: begin
            if (instr[31:26] == TOP6_WSHIFT && f3 == F3_WSHIFT) begin
               kind   = K_WSHIFT;
               zext   = 1'b1;
               amount = instr[20 +: SHW];
            end
         end
         default: ;
      endcase
   end

   // R8: a rejected encoding never asks for the base operand or a shift
   always_comb begin
      if (kind == K_NONE) begin
         a_r8_idle_controls: assert (!use_base && !zext && amount == '0)
            else $error("decode drives controls for a rejected encoding");
      end
   end
endmodule

// File: rtl/agu_zext.sv
module agu_zext #(
   parameter int XLEN  = 64,
   parameter int LOW_W = 32
) (
   input  logic [XLEN-1:0] src,
   input  logic            clear_hi,
   output logic [XLEN-1:0] dst
);
   for (genvar i = 0; i < XLEN; i++) begin : g_bit
      if (i < LOW_W) begin : g_keep
         assign dst[i] = src[i];
      end else begin : g_gate
         assign dst[i] = src[i] & ~clear_hi;
      end
   end

   // R3: with clearing requested the upper field is empty
   always_comb begin
      if (clear_hi) begin
         a_r3_upper_clear: assert ((dst >> LOW_W) == '0)
            else $error("upper field survives zero-extension");
      end
   end
endmodule

// File: rtl/agu_shifter.sv
module agu_shifter #(
   parameter int XLEN = 64,
   localparam int SHW = $clog2(XLEN)
) (
   input  logic [XLEN-1:0] din,
   input  logic [SHW-1:0]  amount,
   output logic [XLEN-1:0] dout
);
   logic [XLEN-1:0] stage [0:SHW];

   assign stage[0] = din;
   for (genvar k = 0; k < SHW; k++) begin : g_stage
      assign stage[k+1] = amount[k] ? (stage[k] << (2 ** k)) : stage[k];
   end
   assign dout = stage[SHW];

   // R6: positions below the shift amount are always zero
   always_comb begin
      a_r6_low_zero: assert ((dout & ~({XLEN{1'b1}} << amount)) == '0)
         else $error("shifter leaves bits below the amount");
   end
endmodule

// File: rtl/agu_adder.sv
module agu_adder #(
   parameter int XLEN  = 64,
   parameter int SPLIT = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] sum
);
   if (SPLIT == 0) begin : g_flat
      assign sum = a + b;
   end else begin : g_csel
      localparam int HI_W = XLEN - SPLIT;
      logic [SPLIT:0]  lo;
      logic [HI_W-1:0] hi_c0;
      logic [HI_W-1:0] hi_c1;
      assign lo    = {1'b0, a[SPLIT-1:0]} + {1'b0, b[SPLIT-1:0]};
      assign hi_c0 = a[XLEN-1:SPLIT] + b[XLEN-1:SPLIT];
      assign hi_c1 = hi_c0 + HI_W'(1);
      assign sum   = {(lo[SPLIT] ? hi_c1 : hi_c0), lo[SPLIT-1:0]};
   end

   // R2: the modular sum inverts through subtraction
   always_comb begin
      a_r2_mod_sum: assert (sum - b == a)
         else $error("adder result is not the modular sum");
   end
endmodule

// File: rtl/scaled_index_agu.sv
module scaled_index_agu
   import agu_pkg::*;
#(
   parameter int XLEN        = 64,
   parameter int LOW_W       = 32,
   parameter int ADDER_SPLIT = 32
) (
   input  logic [31:0]     instr_i,
   input  logic [XLEN-1:0] rs1_i,
   input  logic [XLEN-1:0] rs2_i,
   output logic [XLEN-1:0] result_o,
   output logic            valid_o
);
   localparam int SHW = $clog2(XLEN);

   if (XLEN != 64) begin : g_bad_xlen
      $error("immediate shift field is 6 bits, XLEN must be 64");
   end
   if (LOW_W <= 0 || LOW_W >= XLEN) begin : g_bad_low
      $error("LOW_W must lie strictly inside the datapath");
   end
   if (ADDER_SPLIT < 0 || ADDER_SPLIT >= XLEN) begin : g_bad_split
      $error("ADDER_SPLIT out of range");
   end

   agu_kind_e       kind;
   logic            zext;
   logic            use_base;
   logic [SHW-1:0]  amount;
   logic [XLEN-1:0] index;
   logic [XLEN-1:0] scaled;
   logic [XLEN-1:0] base;
   logic [XLEN-1:0] sum;

   agu_decode #(.XLEN(XLEN)) u_decode (
      .instr    (instr_i),
      .kind     (kind),
      .zext     (zext),
      .use_base (use_base),
      .amount   (amount)
   );

   agu_zext #(.XLEN(XLEN), .LOW_W(LOW_W)) u_zext (
      .src      (rs1_i),
      .clear_hi (zext),
      .dst      (index)
   );

   agu_shifter #(.XLEN(XLEN)) u_shift (
      .din    (index),
      .amount (amount),
      .dout   (scaled)
   );

   assign base = use_base ? rs2_i : '0;

   agu_adder #(.XLEN(XLEN), .SPLIT(ADDER_SPLIT)) u_add (
      .a   (scaled),
      .b   (base),
      .sum (sum)
   );

   assign valid_o  = (kind != K_NONE);
   assign result_o = valid_o ? sum : '0;

   always_comb begin
      // R1: full-width scaled add recovers the shifted index
      if (kind == K_SCALE && !zext) begin
         a_r1_scale_full: assert (result_o - rs2_i == rs1_i << amount)
            else $error("scaled add mismatch");
      end
      // R3: word forms stay below LOW_W + shift once the base is removed
      if (kind == K_SCALE && zext) begin
         a_r3_word_bound: assert (((result_o - rs2_i) >> (LOW_W + 32'(amount))) == '0)
            else $error("word scaled add exceeds index range");
      end
      // R4: unsigned word add gives back the low word
      if (kind == K_WADD) begin
         a_r4_word_add: assert (result_o - rs2_i == XLEN'(rs1_i[LOW_W-1:0]))
            else $error("unsigned word add mismatch");
      end
      // R8: rejected encodings give a zero result
      if (!valid_o) begin
         a_r8_zero_result: assert (result_o == '0)
            else $error("nonzero result without valid");
      end
   end
endmodule

// File: tb/test_scaled_index_agu.sv
module test_scaled_index_agu;
   logic        clk = 1'b0;
   logic [31:0] instr;
   logic [63:0] rs1, rs2, result;
   logic        valid;
   int          n_checks = 0;
   int          n_fail   = 0;
   bit          done     = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   scaled_index_agu i_scaled_index_agu (
      .instr_i  (instr),
      .rs1_i    (rs1),
      .rs2_i    (rs2),
      .result_o (result),
      .valid_o  (valid)
   );

   function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [2:0] f3,
                                         input logic [6:0] maj, input logic [4:0] rd,
                                         input logic [4:0] ra, input logic [4:0] rb);
      return {f7, rb, ra, f3, rd, maj};
   endfunction

   function automatic logic [31:0] enc_sh(input logic b26, input logic [5:0] sh,
                                          input logic [4:0] rd, input logic [4:0] ra);
      return {5'b00001, b26, sh, ra, 3'b001, rd, 7'b0011011};
   endfunction

   task automatic apply(input logic [31:0] i, input logic [63:0] a, input logic [63:0] b);
      @(negedge clk);
      instr = i; rs1 = a; rs2 = b;
      #1;
   endtask

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_op(input string req, input logic [63:0] exp);
      chk(req, {63'b0, valid}, 64'd1);
      chk(req, result, exp);
   endtask

   task automatic chk_bad(input string req);
      chk(req, {63'b0, valid}, 64'd0);
      chk(req, result, 64'd0);
   endtask

   task automatic t_idle();
      apply(32'h0, 64'h1234, 64'h5678);
      chk_bad("R8 all-zero word");          // R8
   endtask

   task automatic t_scale();
      logic [63:0] a, b;
      for (int n = 1; n <= 3; n++) begin
         a = 64'h0000_0000_0000_1000 + 64'(n);
         b = 64'h0000_0000_0000_0020;
         apply(enc_r(7'b0010000, 3'(2 * n), 7'b0110011, 5'd1, 5'd2, 5'd3), a, b);
         chk_op("R1 scale small", (a << n) + b);   // R1
      end
      a = 64'hFFFF_FFFF_8000_0003; b = 64'h0000_0001_0000_0000;
      apply(enc_r(7'b0010000, 3'b100, 7'b0110011, 5'd5, 5'd6, 5'd7), a, b);
      chk_op("R1 scale upper bits kept", (a << 2) + b);
   endtask

   task automatic t_wrap();
      logic [63:0] a, b;
      a = 64'h8000_0000_0000_0001; b = 64'hFFFF_FFFF_FFFF_FFFF;
      apply(enc_r(7'b0010000, 3'b110, 7'b0110011, 5'd1, 5'd1, 5'd1), a, b);
      chk_op("R2 wrap", (a << 3) + b);   // R2
      a = 64'h0000_0000_4000_0000; b = 64'h0;
      apply(enc_r(7'b0010000, 3'b010, 7'b0110011, 5'd1, 5'd1, 5'd1), a, b);
      chk_op("R2 no sign extension", 64'h0000_0000_8000_0000);
   endtask

   task automatic t_scale_word();
      logic [63:0] a, b;
      a = 64'hDEAD_BEEF_F000_0001; b = 64'h0000_1000_0000_0000;
      for (int n = 1; n <= 3; n++) begin
         apply(enc_r(7'b0010000, 3'(2 * n), 7'b0111011, 5'd4, 5'd8, 5'd9), a, b);
         chk_op("R3 word scale", ({32'b0, a[31:0]} << n) + b);   // R3
      end
   endtask

   task automatic t_word_add();
      logic [63:0] a, b;
      a = 64'hFFFF_FFFF_FFFF_FFFF; b = 64'h0000_0000_0000_0001;
      apply(enc_r(7'b0000100, 3'b000, 7'b0111011, 5'd2, 5'd3, 5'd4), a, b);
      chk_op("R4 word add", 64'h0000_0001_0000_0000);   // R4
   endtask

   task automatic t_word_shift();
      logic [63:0] a;
      a = 64'hFFFF_FFFF_8000_0001;
      apply(enc_sh(1'b0, 6'd0, 5'd1, 5'd2), a, 64'h55);
      chk_op("R5 shift by 0", 64'h0000_0000_8000_0001);   // R5
      apply(enc_sh(1'b0, 6'd5, 5'd1, 5'd2), a, 64'h0);
      chk_op("R5 shift by 5", {32'b0, a[31:0]} << 5);
      apply(enc_sh(1'b0, 6'd40, 5'd1, 5'd2), a, 64'hFFFF);
      chk_op("R6 discard past bit 63", 64'h0000_0100_0000_0000);   // R6
      apply(enc_sh(1'b0, 6'd63, 5'd1, 5'd2), 64'h3, 64'h7777);
      chk_op("R6 shift by 63", 64'h8000_0000_0000_0000);
   endtask

   task automatic t_fields();
      logic [63:0] a, b;
      a = 64'h0123_4567_89AB_CDEF; b = 64'h1111;
      apply(enc_r(7'b0010000, 3'b110, 7'b0110011, 5'd0, 5'd0, 5'd0), a, b);
      chk_op("R7 fields zero", (a << 3) + b);   // R7
      apply(enc_r(7'b0010000, 3'b110, 7'b0110011, 5'd31, 5'd17, 5'd29), a, b);
      chk_op("R7 fields set", (a << 3) + b);
   endtask

   task automatic t_illegal();
      apply(enc_r(7'b0010000, 3'b000, 7'b0110011, 5'd1, 5'd2, 5'd3), 64'h9, 64'h9);
      chk_bad("R8 funct3 000");
      apply(enc_r(7'b0010000, 3'b011, 7'b0110011, 5'd1, 5'd2, 5'd3), 64'h9, 64'h9);
      chk_bad("R8 odd funct3");
      apply(enc_r(7'b0010001, 3'b010, 7'b0110011, 5'd1, 5'd2, 5'd3), 64'h9, 64'h9);
      chk_bad("R8 funct7");
      apply(enc_r(7'b0000100, 3'b000, 7'b0110011, 5'd1, 5'd2, 5'd3), 64'h9, 64'h9);
      chk_bad("R8 word add funct7 on full opcode");
      apply(enc_r(7'b0010000, 3'b010, 7'b0010011, 5'd1, 5'd2, 5'd3), 64'h9, 64'h9);
      chk_bad("R8 opcode");
      apply(enc_sh(1'b1, 6'd4, 5'd1, 5'd2), 64'h9, 64'h9);
      chk_bad("R8 shift bit 26 set");
   endtask

   task automatic t_comb();
      // R9: a change of operands alone updates the output with no clock edge
      apply(enc_r(7'b0010000, 3'b010, 7'b0110011, 5'd1, 5'd2, 5'd3), 64'h10, 64'h1);
      @(posedge clk); #0.5;
      rs1 = 64'h20;
      #0.5;
      chk("R9 combinational", result, 64'h41);
   endtask

   initial begin
      instr = '0; rs1 = '0; rs2 = '0;
      t_idle();
      t_scale();
      t_wrap();
      t_scale_word();
      t_word_add();
      t_word_shift();
      t_fields();
      t_illegal();
      t_comb();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule